// File: doc/BRIEF.md
# Calibration Coefficient Byte Reader

This block sits between a host register interface and a small byte-wide store of calibration coefficients. Every output channel owns two 16-bit coefficients, an offset and a gain, and the store keeps each of them as two bytes. To fetch one byte, the host writes a command word into the access register. The block decodes the command, waits a fixed number of cycles for the store, and then raises a ready flag in the status word. The fetched byte is returned in the upper half of that status word.

A complete 16-bit coefficient therefore takes two transactions, one per byte, and the host joins the two bytes. The command is ignored if its start bit is clear, if it names a channel that does not exist, or if a fetch is already in progress. A separate preload port fills the store with known contents. The block does no arithmetic on the coefficients.

Top module: `cal_coef_port`

## Requirements
- R1: While reset is active and after it is released, `status` reads 0000h.
- R2: A command is accepted when `cmd_we` is high, bit 15 is set and no fetch is in progress. From the clock edge that accepts it, `status` reads 0000h for exactly RD_LAT cycles.
- R3: At the RD_LAT-th rising edge after acceptance, status bit 0 becomes 1 and status bits 15:8 take the requested byte. Both then hold until the next accepted command.
- R4: Command bits 9:8 select the byte as follows: 0 is the offset high byte, 1 is the offset low byte, 2 is the gain high byte and 3 is the gain low byte. For channel 0 the four commands are 8000h, 8100h, 8200h and 8300h, and two fetches rebuild one 16-bit coefficient.
- R5: Command bits 14:10 hold the channel index. A command whose index is NUM_CH or greater is ignored and leaves `status` unchanged.
- R6: A write with bit 15 clear is ignored and leaves `status` unchanged.
- R7: A command written while a fetch is in progress is ignored. This includes a command sampled on the same edge that completes the fetch. Once that fetch has completed, the next command is accepted.
- R8: Status bits 7:1 always read as zero.
- R9: A preload write puts `pl_data` at store address {channel, byte select}. The byte select is the low two bits and uses the same encoding as R4. A later fetch returns that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Write strobe for the access register |
| cmd_wdata | input | 16 | Command word |
| pl_en | input | 1 | Preload write strobe for the coefficient store |
| pl_addr | input | ADDR_W | Preload address {channel, byte select} |
| pl_data | input | 8 | Preload byte |
| status | output | 16 | {fetched byte, seven zeros, ready} |

## Verification
Two functions can fall in the same cycle: a fetch completing and a new command arriving. The bench provokes this by timing a second write so that it is sampled on exactly the RD_LAT-th edge after acceptance. The expected result is that the completing byte and its ready flag remain and keep holding for several cycles afterwards. A command sent after that point must then be accepted normally and return its own byte.

// File: rtl/cal_coef_pkg.sv
package cal_coef_pkg;
   typedef enum logic [1:0] {
      SEL_OFS_HI  = 2'd0,
      SEL_OFS_LO  = 2'd1,
      SEL_GAIN_HI = 2'd2,
      SEL_GAIN_LO = 2'd3
   } coef_sel_e;

   localparam int CMD_GO_BIT  = 15;
   localparam int CMD_CH_LSB  = 10;
   localparam int CMD_CH_W    = 5;
   localparam int CMD_SEL_LSB = 8;
   localparam int SEL_W       = 2;
   localparam int BYTE_W      = 8;
   localparam int MAX_CH      = 1 << CMD_CH_W;
endpackage

// File: rtl/cal_cmd_decode.sv
module cal_cmd_decode
   import cal_coef_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CH_W   = 2,
   parameter int ADDR_W = CH_W + SEL_W
) (
   input  logic              cmd_we,
   input  logic [15:0]       cmd_wdata,
   input  logic              busy,
   output logic              accept,
   output logic              ch_ok,
   output logic [ADDR_W-1:0] addr
);
   logic [CMD_CH_W-1:0] ch_idx;
   coef_sel_e           sel;

   always_comb begin
      ch_idx = cmd_wdata[CMD_CH_LSB +: CMD_CH_W];
      sel    = coef_sel_e'(cmd_wdata[CMD_SEL_LSB +: SEL_W]);
      ch_ok  = ({1'b0, ch_idx} < (CMD_CH_W+1)'(NUM_CH));
      accept = cmd_we && cmd_wdata[CMD_GO_BIT] && ch_ok && !busy;
      addr   = {ch_idx[CH_W-1:0], sel};
   end
endmodule

// File: rtl/cal_coef_store.sv
module cal_coef_store
   import cal_coef_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int ADDR_W  = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pl_en,
   input  logic [ADDR_W-1:0] pl_addr,
   input  logic [BYTE_W-1:0] pl_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_data
);
   logic [BYTE_W-1:0] mem [DEPTH];
   logic              pl_hit;

   assign pl_hit = ({1'b0, pl_addr} < (ADDR_W+1)'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (pl_en && pl_hit) begin
         mem[pl_addr] <= pl_data;
      end
   end

   generate
      if (REG_OUT) begin : g_reg_rd
         always_ff @(posedge clk) begin
            if (!rst_n) rd_data <= '0;
            else        rd_data <= mem[rd_addr];
         end
      end else begin : g_comb_rd
         assign rd_data = mem[rd_addr];
      end
   endgenerate

   // R9: a preload lands at the addressed location
   assert_preload_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pl_en && pl_hit) |=> (mem[$past(pl_addr)] == $past(pl_data)));
endmodule

// File: rtl/cal_read_seq.sv
module cal_read_seq
   import cal_coef_pkg::*;
#(
   parameter int RD_LAT = 4,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              busy,
   output logic              ready,
   output logic [BYTE_W-1:0] byte_q
);
   localparam int CNT_W = $clog2(RD_LAT + 1);
   localparam logic [CNT_W-1:0] CNT_START = CNT_W'(RD_LAT - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         ready   <= 1'b0;
         byte_q  <= '0;
         cnt     <= '0;
         rd_addr <= '0;
      end else if (accept) begin
         busy    <= 1'b1;
         ready   <= 1'b0;
         byte_q  <= '0;
         cnt     <= CNT_START;
         rd_addr <= addr_in;
      end else if (busy) begin
         if (cnt == '0) begin
            busy   <= 1'b0;
            ready  <= 1'b1;
            byte_q <= rd_data;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   // R2: acceptance starts a fetch with the flag low
   assert_accept_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy && !ready && byte_q == '0));
   // R2: the latency window counts down one per cycle
   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !accept && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));
   // R3: expiry raises ready with the store output
   assert_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt == '0) |=> (ready && !busy && byte_q == $past(rd_data)));
   // R3: a ready byte holds until a new acceptance
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !accept) |=> (ready && $stable(byte_q)));
   // R7: no acceptance while a fetch is running
   assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !accept);
endmodule

// File: rtl/cal_coef_port.sv
module cal_coef_port
   import cal_coef_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int RD_LAT  = 4,
   parameter bit REG_OUT = 1'b1,
   parameter int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   parameter int ADDR_W  = CH_W + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [15:0]       cmd_wdata,
   input  logic              pl_en,
   input  logic [ADDR_W-1:0] pl_addr,
   input  logic [7:0]        pl_data,
   output logic [15:0]       status
);
   localparam int DEPTH = NUM_CH << SEL_W;

   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
         $error("cal_coef_port: NUM_CH out of range");
      end
      if (RD_LAT < 2) begin : g_bad_lat
         $error("cal_coef_port: RD_LAT must be at least 2");
      end
   endgenerate

   logic              accept, ch_ok, busy, ready;
   logic [ADDR_W-1:0] dec_addr, rd_addr;
   logic [BYTE_W-1:0] rd_data, byte_q;

   cal_cmd_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
      .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .busy(busy),
      .accept(accept), .ch_ok(ch_ok), .addr(dec_addr));

   cal_coef_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_store (
      .clk(clk), .rst_n(rst_n), .pl_en(pl_en), .pl_addr(pl_addr),
      .pl_data(pl_data), .rd_addr(rd_addr), .rd_data(rd_data));

   cal_read_seq #(.RD_LAT(RD_LAT), .ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .accept(accept), .addr_in(dec_addr),
      .rd_data(rd_data), .rd_addr(rd_addr), .busy(busy), .ready(ready),
      .byte_q(byte_q));

   assign status = {byte_q, 7'b0, ready};

   // R6: a write without the start bit while idle changes nothing
   assert_ignore_nogo_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !cmd_wdata[CMD_GO_BIT] && !busy) |=> $stable(status));
   // R5: a write naming a missing channel while idle changes nothing
   assert_ignore_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !ch_ok && !busy) |=> $stable(status));
   // R1: status is clear right after reset
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (status == 16'h0000));
endmodule

// File: tb/cal_coef_port_test.sv
module cal_coef_port_test;
   localparam int NUM_CH = 4;
   localparam int RD_LAT = 4;
   localparam int ADDR_W = 4;

   localparam logic [15:0] OFS  [NUM_CH] = '{16'hFFD5, 16'h1234, 16'h7E81, 16'h5A0F};
   localparam logic [15:0] GAIN [NUM_CH] = '{16'hFF47, 16'hABCD, 16'h3C96, 16'h00C3};
   // {command word, expected byte}
   localparam logic [23:0] VEC [8] = '{
      {16'h8000, 8'hFF}, {16'h8100, 8'hD5}, {16'h8200, 8'hFF}, {16'h8300, 8'h47},
      {16'h8C00, 8'h5A}, {16'h8D00, 8'h0F}, {16'h8E00, 8'h00}, {16'h8F00, 8'hC3}};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_we = 1'b0;
   logic [15:0]       cmd_wdata = '0;
   logic              pl_en = 1'b0;
   logic [ADDR_W-1:0] pl_addr = '0;
   logic [7:0]        pl_data = '0;
   logic [15:0]       status;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cal_coef_port #(.NUM_CH(NUM_CH), .RD_LAT(RD_LAT)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .pl_en(pl_en), .pl_addr(pl_addr), .pl_data(pl_data), .status(status));

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic fetch(input logic [15:0] cmd, input logic [7:0] exp,
                        input string tag, output logic [7:0] got);
      logic low_ok;
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = cmd;
      @(negedge clk); cmd_we = 1'b0; cmd_wdata = '0;
      low_ok = 1'b1;
      for (int i = 0; i < RD_LAT; i++) begin
         if (status !== 16'h0000) low_ok = 1'b0;
         if (i < RD_LAT - 1) @(negedge clk);
      end
      chk("R2 status low during latency", {15'b0, low_ok}, 16'h0001);
      @(negedge clk);
      chk(tag, status, {exp, 8'h01});
      got = status[15:8];
   endtask

   task automatic idle_write(input logic [15:0] w);
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
      @(negedge clk); cmd_we = 1'b0; cmd_wdata = '0;
      repeat (RD_LAT + 2) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] b [8];
      logic [7:0] g;
      repeat (3) @(negedge clk);
      chk("R1 status in reset", status, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 status after reset", status, 16'h0000);

      // R9: preload every byte at {channel, select}
      for (int c = 0; c < NUM_CH; c++) begin
         for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            pl_en = 1'b1;
            pl_addr = ADDR_W'((c << 2) | s);
            case (s)
               0: pl_data = OFS[c][15:8];
               1: pl_data = OFS[c][7:0];
               2: pl_data = GAIN[c][15:8];
               default: pl_data = GAIN[c][7:0];
            endcase
         end
      end
      @(negedge clk); pl_en = 1'b0;
      chk("R1 preload leaves status clear", status, 16'h0000);

      // R4 R9: vector walk over channel 0 and channel 3
      for (int v = 0; v < 8; v++) begin
         fetch(VEC[v][23:8], VEC[v][7:0], "R4 R9 vector fetch", b[v]);
         chk("R8 status bits 7:1 zero", {8'h00, status[7:1], 1'b0}, 16'h0000);
      end
      chk("R4 rebuilt ch0 offset", {b[0], b[1]}, 16'hFFD5);
      chk("R4 rebuilt ch0 gain",   {b[2], b[3]}, 16'hFF47);
      chk("R4 ch0 offset signed -43", 16'($signed({b[0], b[1]}) + 16'sd43), 16'h0000);
      chk("R4 rebuilt ch3 gain",   {b[6], b[7]}, 16'h00C3);

      // R7: command during a fetch and one on the completion edge
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = 16'h8400;
      @(negedge clk); cmd_wdata = 16'h8700;
      @(negedge clk); cmd_we = 1'b0; cmd_wdata = '0;
      repeat (RD_LAT - 2) @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = 16'h8500;
      @(negedge clk); cmd_we = 1'b0; cmd_wdata = '0;
      chk("R3 R7 completion wins over same-edge command", status, 16'h1201);
      repeat (RD_LAT + 1) @(negedge clk);
      chk("R7 ignored commands left byte held", status, 16'h1201);
      fetch(16'h8700, 8'hCD, "R7 command after completion accepted", g);

      // R6: start bit clear
      idle_write(16'h0400);
      chk("R6 write without start bit ignored", status, 16'hCD01);
      // R5: channel index equal to NUM_CH and at the top of the field
      idle_write(16'h9000);
      chk("R5 channel 4 ignored", status, 16'hCD01);
      idle_write(16'hFF00);
      chk("R5 channel 31 ignored", status, 16'hCD01);
      fetch(16'h8A00, 8'h3C, "R5 channel 2 gain high", g);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule